// File: doc/BRIEF.md
# Calibrated Seconds Prescaler

This block divides a slow crystal-rate enable, sampled in the system clock domain, down to a one-second strobe. The number of crystal ticks per second comes from a programmable calibration word. A small fractional trim can stretch chosen seconds by one tick. This lets the long-run average period follow a crystal whose rate is not a whole number of hertz.

The calibration word has three fields. A whole-tick count sits in bits 15:0. A 4-bit fraction F sits in bits 19:16. A trim-enable flag sits in bit 20. A 4-bit sequencer numbers the seconds 0 to 15 and then repeats. When the trim is enabled, the seconds numbered below F last one extra tick.

The running tick count within the current second is exposed, so that software can read time with sub-second resolution. Writing the calibration word restarts both the tick count and the second numbering.

Top module: `sec_prescaler`

## Requirements
- R1: After reset the calibration word is 0x198233: whole count 33331, F = 9, trim enabled. The tick count is 0 and the strobe is low. The first second therefore lasts 33332 ticks.
- R2: Write-data bits above bit 20 are ignored. A write of 0xFFE00005 behaves exactly like a write of 0x000005.
- R3: With bit 20 clear, every second lasts exactly the whole count (bits 15:0) of crystal ticks.
- R4: The second strobe is high for exactly one system clock. It rises in the cycle after the crystal tick that ends the second.
- R5: Each accepted crystal tick advances the tick count by one. The tick that ends a second returns it to 0. With no tick, the count holds.
- R6: With bit 20 set and F in bits 19:16, a second whose position in the repeating 16-second group is below F lasts whole count + 1 ticks. Every other second lasts the whole count.
- R7: With bit 20 clear, the value of F has no effect on second length.
- R8: A calibration write clears the tick count and the second numbering. It produces no strobe. The next second is numbered 0.
- R9: A crystal tick that arrives in the same cycle as a calibration write is dropped.
- R10: A whole count of 0 with the trim disabled gives a strobe on every crystal tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xtal_tick | input | 1 | One-cycle enable per crystal period |
| cal_wr | input | 1 | Calibration write strobe |
| cal_wdata | input | 32 | Calibration write data; only bits 20:0 are kept |
| sec_pulse | output | 1 | One-cycle strobe at the end of each second |
| tick_cnt | output | 16 | Crystal ticks counted in the current second |

## Verification
On every cycle, the checker confirms four things. The tick count steps by one per accepted tick, or returns to zero together with a strobe. It holds when there is no tick. It never passes the programmed whole count plus one. A write always leaves a cleared count and no strobe.

The length of each second is a property of a whole sequence, and so is the pattern of stretched seconds across a 16-second group. Only the bench scenarios can show these. They do so by counting ticks between strobes under several calibration words, including the reset default and a restart in mid-second.

// File: rtl/sec_prescaler_pkg.sv
package sec_prescaler_pkg;
    localparam int TICK_W = 16;
    localparam int FRAC_W = 4;
    localparam int CAL_W  = TICK_W + FRAC_W + 1;

    typedef struct packed {
        logic              trim_en;
        logic [FRAC_W-1:0] frac;
        logic [TICK_W-1:0] whole;
    } cal_t;

    localparam logic [CAL_W-1:0] CAL_RESET_RAW = 21'h198233;
    localparam cal_t CAL_RESET = cal_t'(CAL_RESET_RAW);
endpackage

// File: rtl/sec_prescaler_cal_reg.sv
module sec_prescaler_cal_reg
    import sec_prescaler_pkg::*;
#(
    parameter int WDATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [WDATA_W-1:0] wdata,
    output cal_t               cal
);
    typedef struct packed {
        cal_t cal;
    } state_t;

    state_t state_d, state_q;

    generate
        if (WDATA_W > CAL_W) begin : g_spare
            logic spare_unused;
            assign spare_unused = ^wdata[WDATA_W-1:CAL_W];
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        if (wr) begin
            state_d.cal = cal_t'(wdata[CAL_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.cal <= CAL_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    assign cal = state_q.cal;
endmodule

// File: rtl/sec_prescaler_frac_seq.sv
module sec_prescaler_frac_seq
    import sec_prescaler_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic sec_done,
    input  cal_t cal,
    output logic stretch
);
    typedef struct packed {
        logic [FRAC_W-1:0] idx;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d.idx = '0;
        end else if (sec_done) begin
            state_d.idx = state_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.idx <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign stretch = cal.trim_en && (state_q.idx < cal.frac);
endmodule

// File: rtl/sec_prescaler_tick_ctr.sv
module sec_prescaler_tick_ctr
    import sec_prescaler_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              tick,
    input  logic [TICK_W-1:0] whole,
    input  logic              stretch,
    output logic              sec_done,
    output logic              pulse,
    output logic [TICK_W-1:0] cnt
);
    typedef struct packed {
        logic [TICK_W-1:0] cnt;
        logic              pulse;
    } state_t;

    state_t            state_d, state_q;
    logic [TICK_W:0]   next_cnt;
    logic [TICK_W:0]   target;

    always_comb begin
        next_cnt = {1'b0, state_q.cnt} + 1'b1;
        target   = {1'b0, whole} + {{TICK_W{1'b0}}, stretch};
        sec_done = tick && !restart && (next_cnt >= target);

        state_d       = state_q;
        state_d.pulse = 1'b0;
        if (restart) begin
            state_d.cnt = '0;
        end else if (tick) begin
            if (sec_done) begin
                state_d.cnt   = '0;
                state_d.pulse = 1'b1;
            end else begin
                state_d.cnt = next_cnt[TICK_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.cnt   <= '0;
            state_q.pulse <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pulse = state_q.pulse;
    assign cnt   = state_q.cnt;
endmodule

// File: rtl/sec_prescaler.sv
module sec_prescaler
    import sec_prescaler_pkg::*;
#(
    parameter int WDATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               xtal_tick,
    input  logic               cal_wr,
    input  logic [WDATA_W-1:0] cal_wdata,
    output logic               sec_pulse,
    output logic [TICK_W-1:0]  tick_cnt
);
    cal_t cal;
    logic stretch;
    logic sec_done;

    sec_prescaler_cal_reg #(.WDATA_W(WDATA_W)) cal_reg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cal_wr),
        .wdata (cal_wdata),
        .cal   (cal)
    );

    sec_prescaler_frac_seq frac_seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (cal_wr),
        .sec_done (sec_done),
        .cal      (cal),
        .stretch  (stretch)
    );

    sec_prescaler_tick_ctr tick_ctr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (cal_wr),
        .tick     (xtal_tick),
        .whole    (cal.whole),
        .stretch  (stretch),
        .sec_done (sec_done),
        .pulse    (sec_pulse),
        .cnt      (tick_cnt)
    );
endmodule

// File: rtl/sec_prescaler_checker.sv
module sec_prescaler_checker
    import sec_prescaler_pkg::*;
#(
    parameter int WDATA_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               xtal_tick,
    input logic               cal_wr,
    input logic [WDATA_W-1:0] cal_wdata,
    input logic               sec_pulse,
    input logic [TICK_W-1:0]  tick_cnt
);
    logic [TICK_W-1:0] shadow_whole;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_whole <= CAL_RESET.whole;
        end else if (cal_wr) begin
            shadow_whole <= cal_wdata[TICK_W-1:0];
        end
    end

    // R4: a strobe only follows an accepted crystal tick
    a_r4_pulse_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |-> $past(xtal_tick && !cal_wr));

    // R5: a strobe coincides with a cleared count
    a_r5_pulse_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |-> (tick_cnt == '0));

    // R5: the count holds without a tick
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!xtal_tick && !cal_wr) |=> ($stable(tick_cnt) && !sec_pulse));

    // R5: an accepted tick steps the count or ends the second
    a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
        (xtal_tick && !cal_wr) |=>
            ((tick_cnt == $past(tick_cnt) + 1'b1) || (sec_pulse && tick_cnt == '0)));

    // R8 / R9: a write clears the count and gives no strobe
    a_r8_write_restart: assert property (@(posedge clk) disable iff (!rst_n)
        cal_wr |=> (tick_cnt == '0 && !sec_pulse));

    // R3 / R6: the count stays within the programmed second
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tick_cnt <= shadow_whole);
endmodule

bind sec_prescaler sec_prescaler_checker #(.WDATA_W(WDATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .xtal_tick (xtal_tick),
    .cal_wr    (cal_wr),
    .cal_wdata (cal_wdata),
    .sec_pulse (sec_pulse),
    .tick_cnt  (tick_cnt)
);

// File: tb/sec_prescaler_tb_top.sv
`timescale 1ns/1ps
module sec_prescaler_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xtal_tick = 1'b0;
    logic        cal_wr = 1'b0;
    logic [31:0] cal_wdata = '0;
    logic        sec_pulse;
    logic [15:0] tick_cnt;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sec_prescaler dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .xtal_tick (xtal_tick),
        .cal_wr    (cal_wr),
        .cal_wdata (cal_wdata),
        .sec_pulse (sec_pulse),
        .tick_cnt  (tick_cnt)
    );

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic do_tick();
        @(negedge clk) xtal_tick = 1'b1;
        @(negedge clk) xtal_tick = 1'b0;
    endtask

    task automatic write_cal(logic [31:0] w);
        @(negedge clk) begin cal_wr = 1'b1; cal_wdata = w; end
        @(negedge clk) cal_wr = 1'b0;
    endtask

    task automatic measure(string req, int expected);
        int len = 0;
        bit seen = 1'b0;
        while (!seen && len < 70000) begin
            do_tick();
            len++;
            seen = sec_pulse;
        end
        check(req, len, expected);
        check("R5 count zero at strobe", tick_cnt, 0);
        @(negedge clk);
        check("R4 strobe one cycle", sec_pulse, 0);
    endtask

    task automatic t_reset_default();
        check("R1 reset count", tick_cnt, 0);
        check("R1 reset strobe", sec_pulse, 0);
        measure("R1 default first second", 33332);
    endtask

    task automatic t_subsecond();
        write_cal(32'h0000_0010);
        for (int i = 1; i <= 3; i++) begin
            do_tick();
            check("R5 tick count", tick_cnt, i);
        end
        repeat (10) @(negedge clk);
        check("R5 hold without tick", tick_cnt, 3);
        check("R5 no strobe idle", sec_pulse, 0);
    endtask

    task automatic t_plain();
        write_cal(32'h0000_0005);
        for (int s = 0; s < 20; s++) measure("R3 plain second", 5);
    endtask

    task automatic t_frac_disabled();
        write_cal(32'h0007_0006);
        for (int s = 0; s < 20; s++) measure("R7 fraction ignored", 6);
    endtask

    task automatic t_frac(logic [31:0] w, int whole, int f, int nsec);
        write_cal(w);
        for (int s = 0; s < nsec; s++)
            measure("R6 trimmed second", ((s % 16) < f) ? whole + 1 : whole);
    endtask

    task automatic t_upper_bits();
        write_cal(32'hFFE0_0005);
        for (int s = 0; s < 18; s++) measure("R2 upper bits ignored", 5);
    endtask

    task automatic t_restart();
        write_cal(32'h0012_0008);
        measure("R6 before restart", 9);
        measure("R6 before restart", 9);
        for (int i = 0; i < 5; i++) do_tick();
        check("R5 mid second count", tick_cnt, 5);
        write_cal(32'h0012_0008);
        check("R8 count cleared", tick_cnt, 0);
        check("R8 no strobe on write", sec_pulse, 0);
        measure("R8 renumbered second 0", 9);
        measure("R8 renumbered second 1", 9);
        measure("R8 renumbered second 2", 8);
    endtask

    task automatic t_write_with_tick();
        write_cal(32'h0000_0004);
        do_tick();
        do_tick();
        @(negedge clk) begin cal_wr = 1'b1; cal_wdata = 32'h0000_0004; xtal_tick = 1'b1; end
        @(negedge clk) begin cal_wr = 1'b0; xtal_tick = 1'b0; end
        check("R9 tick dropped on write", tick_cnt, 0);
        measure("R9 full second after write", 4);
    endtask

    task automatic t_zero_whole();
        write_cal(32'h0000_0000);
        for (int s = 0; s < 5; s++) measure("R10 strobe every tick", 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_default();
        t_subsecond();
        t_plain();
        t_frac_disabled();
        t_frac(32'h0013_0004, 4, 3, 32);
        t_frac(32'h001F_0003, 3, 15, 16);
        t_upper_bits();
        t_restart();
        t_write_with_tick();
        t_zero_whole();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule